// File: doc/BRIEF.md
# Serial EEPROM Sequential Word Reader

This block is a host-side master that fetches a run of consecutive 16-bit words from a three-wire serial EEPROM: chip select, serial clock and data out, plus data in sampled from the memory. A one-cycle start pulse loads a start address and a word count. For every word the block frames a complete, self-contained read transaction: it raises chip select, sends the read command, shifts out the address, shifts back the reply and then releases chip select.

Each returned word appears on a data bus with a one-cycle valid strobe and the word's index within the run (address minus start address). The block stays busy until the frame of the final word has closed and then gives a one-cycle done pulse. The lengths of the serial clock phases are derived from the system clock period, which is a parameter, so that the memory's minimum high and low times are met.

Top module: `eeprom_seq_reader`

## Requirements
- R1: After reset, mw_cs, mw_sk and mw_do are low, and busy and done are low.
- R2: Each word frame begins with mw_cs rising while mw_sk is low. Exactly one full serial clock cycle with mw_do low passes before the start bit, and the start bit is followed by the read opcode bits 1 then 0. All three command bits are sampled by the memory on rising mw_sk edges.
- R3: After the opcode, the address is sent as ADDR_W bits, MSB first. The address of word i is (start_addr + i) modulo 2^ADDR_W, so the run wraps past the top address.
- R4: The reply is sampled over 17 serial clock cycles, in the last system cycle of each low phase. The first sampled bit is the leading dummy zero and is dropped. The next 16 bits form word_data, MSB first.
- R5: Each word is presented with a one-cycle word_valid pulse. word_idx counts 0, 1, …, word_count−1 in order, and exactly word_count pulses occur per run.
- R6: After the reply of each word, mw_cs is low for exactly one full serial clock cycle (one rising mw_sk edge) before the next frame or the end of the run.
- R7: mw_sk stays high for at least ceil(750/SYS_CLK_NS) system cycles and low for at least ceil(250/SYS_CLK_NS) system cycles. mw_do does not change while mw_sk is high.
- R8: busy is high from the cycle after an accepted start until the final frame closes. done then pulses for one cycle while busy is low, and word_valid is never high while busy is low.
- R9: A start with word_count = 0 gives a done pulse in the next cycle. busy stays low and mw_cs never rises.
- R10: A start pulse while busy is ignored. The current run continues with its original address and count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a run |
| start_addr | input | ADDR_W | First word address of the run |
| word_count | input | CNT_W | Number of words to read |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at end of run |
| word_valid | output | 1 | One-cycle strobe for word_data/word_idx |
| word_idx | output | CNT_W | Index of the presented word within the run |
| word_data | output | 16 | Word read from the memory |
| mw_cs | output | 1 | Chip select to the memory |
| mw_sk | output | 1 | Serial clock to the memory |
| mw_do | output | 1 | Serial data to the memory |
| mw_di | input | 1 | Serial data from the memory |

## Verification
The bench builds the block with ADDR_W = 6 and SYS_CLK_NS = 100, which gives 3-cycle low phases and 8-cycle high phases. These short phases keep each frame near 300 system cycles, so single-word runs, multi-word runs, a zero-length run and an ignored mid-run start all fit into one short simulation. The 6-bit address makes the wrap from address 63 to 0 reachable with a three-word run. A behavioural memory model on the serial pins decodes each frame and checks the command and address, and the bench measures every phase length.

// File: rtl/eeprom_rd_pkg.sv
package eeprom_rd_pkg;

  // Rounded-up integer division used for phase lengths.
  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  // Slot layout of one frame: select, 3 command, aw address, 17 reply, release.
  function automatic int frame_slots(input int aw);
    return 22 + aw;
  endfunction

  function automatic int rd_first(input int aw);
    return 4 + aw;
  endfunction

  function automatic int rd_last(input int aw);
    return 20 + aw;
  endfunction

  function automatic int rel_slot(input int aw);
    return 21 + aw;
  endfunction

  // Serial data out level for a given slot of the frame.
  function automatic logic frame_bit(input int slot, input logic [7:0] addr, input int aw);
    logic b;
    b = 1'b0;
    if (slot == 1 || slot == 2) b = 1'b1;
    else if (slot >= 4 && slot < 4 + aw) b = addr[aw - 1 - (slot - 4)];
    return b;
  endfunction

  function automatic logic in_reply(input int slot, input int aw);
    return (slot >= rd_first(aw)) && (slot <= rd_last(aw));
  endfunction

endpackage

// File: rtl/sk_phase_timer.sv
module sk_phase_timer #(
  parameter int LO_CYC = 3,
  parameter int HI_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sk,
  output logic sample_tick,
  output logic slot_tick
);
  localparam int MAXC = (HI_CYC > LO_CYC) ? HI_CYC : LO_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt;

  assign sample_tick = run && !sk && (cnt == CW'(LO_CYC - 1));
  assign slot_tick   = run &&  sk && (cnt == CW'(HI_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sk  <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      sk  <= 1'b0;
    end else if (sample_tick) begin
      cnt <= '0;
      sk  <= 1'b1;
    end else if (slot_tick) begin
      cnt <= '0;
      sk  <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R4: the reply sample is taken in the cycle just before the clock rises.
  p_sample_then_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick |=> sk);

  // R7: a slot ends only by a falling clock.
  p_slot_then_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_tick && run) |=> !sk);

endmodule

// File: rtl/rx_shift.sv
module rx_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] word
);
  // W+1 shifts per frame push the leading dummy bit off the top.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word <= '0;
    else if (shift_en) word <= {word[W-2:0], din};
  end
endmodule

// File: rtl/eeprom_seq_reader.sv
module eeprom_seq_reader
  import eeprom_rd_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int SYS_CLK_NS = 10,
  parameter int CNT_W      = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  word_count,
  output logic              busy,
  output logic              done,
  output logic              word_valid,
  output logic [CNT_W-1:0]  word_idx,
  output logic [15:0]       word_data,
  output logic              mw_cs,
  output logic              mw_sk,
  output logic              mw_do,
  input  logic              mw_di
);
  localparam int LO_CYC = ceil_div(250, SYS_CLK_NS);
  localparam int HI_CYC = ceil_div(750, SYS_CLK_NS);
  localparam int SLOTS  = frame_slots(ADDR_W);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int RD_END = rd_last(ADDR_W);
  localparam int REL    = rel_slot(ADDR_W);

  logic              run;
  logic [SLOT_W-1:0] slot;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  idx_q;
  logic [CNT_W-1:0]  rem_q;

  // Named internal events for the assertions.
  logic sample_tick, slot_tick;
  logic accept_start, zero_start, frame_close, reply_end, last_word;

  assign accept_start = start && !run && (word_count != '0);
  assign zero_start   = start && !run && (word_count == '0);
  assign frame_close  = slot_tick && (slot == SLOT_W'(REL));
  assign reply_end    = slot_tick && (slot == SLOT_W'(RD_END));
  assign last_word    = (rem_q == CNT_W'(1));

  sk_phase_timer #(.LO_CYC(LO_CYC), .HI_CYC(HI_CYC)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .sk          (mw_sk),
    .sample_tick (sample_tick),
    .slot_tick   (slot_tick)
  );

  rx_shift #(.W(16)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (sample_tick && in_reply(int'(slot), ADDR_W)),
    .din      (mw_di),
    .word     (word_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run        <= 1'b0;
      slot       <= '0;
      addr_q     <= '0;
      idx_q      <= '0;
      rem_q      <= '0;
      done       <= 1'b0;
      word_valid <= 1'b0;
      word_idx   <= '0;
    end else begin
      done       <= zero_start || (frame_close && last_word);
      word_valid <= reply_end;
      if (reply_end) word_idx <= idx_q;
      if (accept_start) begin
        run    <= 1'b1;
        slot   <= '0;
        addr_q <= start_addr;
        idx_q  <= '0;
        rem_q  <= word_count;
      end else if (frame_close) begin
        slot <= '0;
        if (last_word) begin
          run <= 1'b0;
        end else begin
          rem_q  <= rem_q - 1'b1;
          idx_q  <= idx_q + 1'b1;
          addr_q <= addr_q + 1'b1;
        end
      end else if (slot_tick) begin
        slot <= slot + 1'b1;
      end
    end
  end

  assign busy  = run;
  assign mw_cs = run && (slot != SLOT_W'(REL));
  assign mw_do = run && frame_bit(int'(slot), 8'(addr_q), ADDR_W);

  // R7: data out holds while the serial clock is high.
  p_do_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_sk && $past(mw_sk)) |-> $stable(mw_do));

  // R8: done pulses only once the run has ended.
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R5, R6: a word is presented during the release slot of its frame.
  p_valid_in_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> (busy && !mw_cs));

  // R9: nothing moves on the serial pins while idle.
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mw_cs && !mw_sk && !mw_do));

  // R10: a start seen during a run does not end or restart it.
  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !frame_close) |=> busy);

  // R2: chip select never rises while the clock is high.
  p_cs_rise_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mw_cs) |-> !mw_sk);

endmodule

// File: tb/eeprom_seq_reader_tb.sv
`timescale 1ns/1ps
module eeprom_seq_reader_tb;
  localparam int CLK_PERIOD = 100;
  localparam int AW   = 6;
  localparam int CW   = AW + 1;
  localparam int HI_E = (750 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int LO_E = (250 + CLK_PERIOD - 1) / CLK_PERIOD;

  logic clk = 0, rst_n = 0, start = 0;
  logic [AW-1:0] start_addr = '0;
  logic [CW-1:0] word_count = '0;
  logic busy, done, word_valid, mw_cs, mw_sk, mw_do;
  logic [CW-1:0] word_idx;
  logic [15:0] word_data;
  logic mw_di = 1'b0;

  int checks = 0, errors = 0;

  eeprom_seq_reader #(.ADDR_W(AW), .SYS_CLK_NS(CLK_PERIOD), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .word_count(word_count), .busy(busy), .done(done), .word_valid(word_valid),
    .word_idx(word_idx), .word_data(word_data), .mw_cs(mw_cs), .mw_sk(mw_sk),
    .mw_do(mw_do), .mw_di(mw_di));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] mem_word(input logic [AW-1:0] a);
    logic [7:0] b;
    b = 8'(a);
    return {b ^ 8'h5A, ~b} ^ 16'h8001;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Memory model on the serial pins.
  int pre_rises = 0, bitcnt = 0, outcnt = 0;
  bit started = 0;
  logic [15:0] shreg = '0;
  logic [AW-1:0] cur_a = '0;
  int proto_err = 0, cs_low_rises = 0, seen_n = 0;
  int seen_addr [64];

  always @(posedge mw_sk or posedge mw_cs) begin
    if (mw_cs && !mw_sk) begin
      started = 0; pre_rises = 0; bitcnt = 0; outcnt = 0; mw_di <= 1'b0;
    end else if (!mw_cs) begin
      cs_low_rises++;
      mw_di <= 1'b0;
    end else if (!started) begin
      if (mw_do) begin
        started = 1;
        if (pre_rises != 1) proto_err++;
      end else pre_rises++;
    end else if (bitcnt < 2 + AW) begin
      shreg = {shreg[14:0], mw_do};
      bitcnt++;
      if (bitcnt == 2 + AW) begin
        if (shreg[AW+1:AW] != 2'b10) proto_err++;
        cur_a = shreg[AW-1:0];
        seen_addr[seen_n % 64] = int'(cur_a);
        seen_n++;
        mw_di <= 1'b0;
      end
    end else begin
      if (outcnt < 16) mw_di <= mem_word(cur_a)[15 - outcnt];
      else mw_di <= 1'b0;
      outcnt++;
    end
  end

  // Output monitor sampled away from the active edge.
  int got_n = 0, done_n = 0, vnb = 0, cs_rise_n = 0, busy_done = 0;
  int got_data [64];
  int got_idx  [64];
  int hi_min = 1000, lo_min = 1000, run_len = 0;
  logic prev_sk = 0, prev_busy = 0, prev_cs = 0;

  always @(negedge clk) begin
    if (word_valid) begin
      got_data[got_n % 64] = int'(word_data);
      got_idx[got_n % 64]  = int'(word_idx);
      got_n++;
      if (!busy) vnb++;
    end
    if (done) begin
      done_n++;
      if (busy) busy_done++;
    end
    if (mw_cs && !prev_cs) cs_rise_n++;
    if (prev_busy && (!busy || mw_sk != prev_sk)) begin
      if (prev_sk) hi_min = (run_len < hi_min) ? run_len : hi_min;
      else         lo_min = (run_len < lo_min) ? run_len : lo_min;
    end
    if (busy) run_len = (prev_busy && mw_sk == prev_sk) ? run_len + 1 : 1;
    prev_sk = mw_sk; prev_busy = busy; prev_cs = mw_cs;
  end

  task automatic pulse_start(input logic [AW-1:0] a, input logic [CW-1:0] n);
    @(negedge clk);
    start_addr = a; word_count = n; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int base;
    base = done_n;
    for (int t = 0; t < 20000 && done_n == base; t++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 pins", {29'd0, mw_cs, mw_sk, mw_do}, 32'd0);
    chk("R1 status", {30'd0, busy, done}, 32'd0);
  endtask

  task automatic t_zero();
    int cr, gn;
    cr = cs_rise_n; gn = got_n;
    @(negedge clk);
    start_addr = 6'd9; word_count = '0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 done next cycle", {31'd0, done}, 32'd1);
    chk("R9 busy low", {31'd0, busy}, 32'd0);
    repeat (30) @(negedge clk);
    chk("R9 no cs", cs_rise_n - cr, 0);
    chk("R9 no words", got_n - gn, 0);
  endtask

  task automatic t_run(input logic [AW-1:0] a, input int n);
    int gb, sb, cl, pe, dn;
    gb = got_n; sb = seen_n; cl = cs_low_rises; pe = proto_err; dn = done_n;
    pulse_start(a, CW'(n));
    chk("R8 busy after start", {31'd0, busy}, 32'd1);
    wait_done();
    chk("R8 one done", done_n - dn, 1);
    chk("R8 busy low at done", {31'd0, busy}, 32'd0);
    @(negedge clk);
    chk("R8 done one cycle", {31'd0, done}, 32'd0);
    chk("R5 word count", got_n - gb, n);
    chk("R2 framing", proto_err - pe, 0);
    chk("R6 release cycles", cs_low_rises - cl, n);
    for (int i = 0; i < n; i++) begin
      logic [AW-1:0] ea;
      ea = a + AW'(i);
      chk("R3 address", seen_addr[(sb + i) % 64], int'(ea));
      chk("R4 data", got_data[(gb + i) % 64], int'(mem_word(ea)));
      chk("R5 index", got_idx[(gb + i) % 64], i);
    end
  endtask

  task automatic t_busy_ignore();
    int gb, sb;
    gb = got_n; sb = seen_n;
    pulse_start(6'd10, CW'(2));
    repeat (100) @(negedge clk);
    pulse_start(6'd40, CW'(5));
    wait_done();
    repeat (2) @(negedge clk);
    chk("R10 word count kept", got_n - gb, 2);
    chk("R10 address kept", seen_addr[(sb + 1) % 64], 11);
    chk("R10 data kept", got_data[(gb + 1) % 64], int'(mem_word(6'd11)));
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_zero();
    t_run(6'd5, 1);
    t_run(6'd20, 4);
    t_run(6'd62, 3);
    t_busy_ignore();
    chk("R7 high time", {31'd0, hi_min >= HI_E}, 32'd1);
    chk("R7 low time", {31'd0, lo_min >= LO_E}, 32'd1);
    chk("R8 valid only busy", vnb, 0);
    chk("R8 done never busy", busy_done, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule